// File: doc/BRIEF.md
# Receive Message Object Filter Bank

This block holds a bank of receive message objects and chooses which one takes each incoming frame. Each object has an identifier, an optional per-bit mask, format and direction settings, a data length and an eight-byte data buffer. A frame from the protocol engine arrives with a one-cycle strobe. The frame carries an identifier, an extended-format flag, a direction flag, a data length code and eight data bytes. The block compares the frame against every object in parallel. The lowest-numbered qualifying object receives the frame.

The winning object stores the length and the data. Its new-data flag is set. Its message-lost flag is set when unread data is overwritten. If the object has interrupts enabled, its interrupt-pending flag is set too. A frame that no object accepts raises a no-match pulse and changes no state. A configuration write port loads one object at a time. A registered read port returns an object's stored length, data and flags.

Top module: `rx_obj_filter`

## Requirements
- R1: After a synchronous reset, every object is invalid and its new-data, message-lost and interrupt-pending flags read 0. The hit and nomatch outputs are 0.
- R2: An object takes part in matching only when its valid setting is 1 and its direction setting is 0. An object with direction 1 (transmit) or with valid 0 never wins.
- R3: When an object's use-mask setting is 0, a frame matches only if the identifier, the extended flag and the direction flag are all equal to the object's values.
- R4: When use-mask is 1, an identifier mask bit of 1 compares that identifier bit and a bit of 0 ignores it. An all-zero mask with mask-extended 0 and mask-direction 0 accepts every frame.
- R5: An extended frame (extended flag 1) compares all 29 identifier bits [28:0]. A standard frame (extended flag 0) holds its 11-bit identifier in bits [28:18] and compares only those bits. Bits [17:0] are ignored for standard frames.
- R6: With use-mask set, the mask-extended setting decides whether the extended flag is compared, and the mask-direction setting decides whether the direction flag is compared.
- R7: When several objects qualify, the object with the lowest index (index 0 highest priority) wins, and hit_idx reports it.
- R8: The winning object stores the received DLC and all eight data bytes, with frame byte 0 at rd_data[7:0] and byte k at rd_data[8k+7:8k]. Bytes at positions at or beyond the DLC are unspecified.
- R9: A store sets the winner's new-data flag. If new-data was already 1, the store also sets message-lost.
- R10: A store sets the winner's interrupt-pending flag when its interrupt-enable setting is 1. Otherwise interrupt-pending keeps its value.
- R11: A strobe that finds no qualifying object pulses nomatch for one cycle and leaves every object's flags unchanged. hit and nomatch are never high together.
- R12: hit, hit_idx and nomatch are valid in the cycle after the frame strobe. Read outputs are valid in the cycle after rd_idx is sampled.
- R13: A configuration write loads the object's settings and clears its new-data, message-lost and interrupt-pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Object index to configure |
| cfg_id | input | ID_W | Object identifier (standard ID in [28:18]) |
| cfg_mask | input | ID_W | Identifier mask, 1 = compare |
| cfg_xtd | input | 1 | Object expects extended format |
| cfg_dir | input | 1 | Direction, 0 = receive |
| cfg_valid | input | 1 | Object valid |
| cfg_umask | input | 1 | Use the mask settings |
| cfg_mxtd | input | 1 | Compare extended flag when masking |
| cfg_mdir | input | 1 | Compare direction flag when masking |
| cfg_rxie | input | 1 | Set interrupt-pending on store |
| frm_valid | input | 1 | One-cycle frame strobe |
| frm_id | input | ID_W | Frame identifier |
| frm_xtd | input | 1 | Frame extended flag |
| frm_dir | input | 1 | Frame direction flag |
| frm_dlc | input | DLC_W | Frame data length code |
| frm_data | input | 8*DATA_BYTES | Frame data, byte 0 in bits [7:0] |
| hit | output | 1 | Frame stored (one-cycle pulse) |
| nomatch | output | 1 | No object accepted the frame (pulse) |
| hit_idx | output | IDX_W | Index of the object that took the frame |
| rd_idx | input | IDX_W | Object index to read |
| rd_data | output | 8*DATA_BYTES | Stored data bytes |
| rd_dlc | output | DLC_W | Stored DLC |
| rd_newdat | output | 1 | New-data flag |
| rd_msglst | output | 1 | Message-lost flag |
| rd_intpnd | output | 1 | Interrupt-pending flag |

## Verification
The assertions check several properties on every cycle. hit and nomatch are never high together. Both pulse only after a strobe. A hit always leaves the winner's new-data flag set. A no-match leaves all flags unchanged. The priority encoder only grants a requesting object, and only qualified objects report a match. The bench scenarios cover the rest by comparing against a reference model. They show which object wins under exact, masked and standard-format matching, and how the mask-extended and mask-direction settings act. They also show the stored length and bytes, the message-lost and interrupt-pending sequences, and flag clearing by a configuration write.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic [28:0] id;
    logic [28:0] mask;
    logic        xtd;
    logic        dir;
    logic        valid;
    logic        umask;
    logic        mxtd;
    logic        mdir;
    logic        rxie;
  } obj_cfg_t;
endpackage

// File: rtl/obj_match.sv
module obj_match #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  rxf_pkg::obj_cfg_t cfg,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_xtd,
  input  logic              frm_dir,
  output logic              match
);
  localparam logic [ID_W-1:0] STD_SPAN = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] eff_mask;
  logic            cmp_xtd, cmp_dir, id_ok, xtd_ok, dir_ok, qual;

  always_comb begin
    eff_mask = cfg.umask ? cfg.mask[ID_W-1:0] : {ID_W{1'b1}};
    if (!frm_xtd) eff_mask = eff_mask & STD_SPAN;
    cmp_xtd = cfg.umask ? cfg.mxtd : 1'b1;
    cmp_dir = cfg.umask ? cfg.mdir : 1'b1;
    id_ok   = ((frm_id ^ cfg.id[ID_W-1:0]) & eff_mask) == '0;
    xtd_ok  = !cmp_xtd || (frm_xtd == cfg.xtd);
    dir_ok  = !cmp_dir || (frm_dir == cfg.dir);
    qual    = cfg.valid && !cfg.dir;
    match   = qual && id_ok && xtd_ok && dir_ok;
  end

  always_comb begin
    if (match) assert_qualified_R2: assert (cfg.valid && !cfg.dir);
  end
endmodule

// File: rtl/prio_lowest.sv
module prio_lowest #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) assert_grant_requested_R7: assert (req[idx]);
  end
endmodule

// File: rtl/obj_store.sv
module obj_store #(
  parameter int N = 32,
  parameter int W = 68,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rx_obj_filter.sv
module rx_obj_filter #(
  parameter int NUM_OBJ    = 32,
  parameter int ID_W       = 29,
  parameter int STD_W      = 11,
  parameter int DATA_BYTES = 8,
  parameter int DLC_W      = 4,
  localparam int IDX_W     = $clog2(NUM_OBJ),
  localparam int DATA_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [ID_W-1:0]   cfg_mask,
  input  logic              cfg_xtd,
  input  logic              cfg_dir,
  input  logic              cfg_valid,
  input  logic              cfg_umask,
  input  logic              cfg_mxtd,
  input  logic              cfg_mdir,
  input  logic              cfg_rxie,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_xtd,
  input  logic              frm_dir,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [DATA_W-1:0] frm_data,
  output logic              hit,
  output logic              nomatch,
  output logic [IDX_W-1:0]  hit_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DLC_W-1:0]  rd_dlc,
  output logic              rd_newdat,
  output logic              rd_msglst,
  output logic              rd_intpnd
);
  import rxf_pkg::*;

  localparam int MEM_W = DATA_W + DLC_W;

  obj_cfg_t           cfg_q [NUM_OBJ];
  logic [NUM_OBJ-1:0] match_vec;
  logic [NUM_OBJ-1:0] newdat_q, msglst_q, intpnd_q;
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;
  logic               store;
  logic [MEM_W-1:0]   rd_word;

  assign store = frm_valid && any_match;

  // Per-object configuration registers and comparators
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        cfg_q[g].id    <= cfg_id;
        cfg_q[g].mask  <= cfg_mask;
        cfg_q[g].xtd   <= cfg_xtd;
        cfg_q[g].dir   <= cfg_dir;
        cfg_q[g].valid <= cfg_valid;
        cfg_q[g].umask <= cfg_umask;
        cfg_q[g].mxtd  <= cfg_mxtd;
        cfg_q[g].mdir  <= cfg_mdir;
        cfg_q[g].rxie  <= cfg_rxie;
      end
    end

    obj_match #(.ID_W(ID_W), .STD_W(STD_W)) u_match (
      .cfg    (cfg_q[g]),
      .frm_id (frm_id),
      .frm_xtd(frm_xtd),
      .frm_dir(frm_dir),
      .match  (match_vec[g])
    );

    // Status flags: a store sets them, a configuration write clears them
    always_ff @(posedge clk) begin
      if (rst) begin
        newdat_q[g] <= 1'b0;
        msglst_q[g] <= 1'b0;
        intpnd_q[g] <= 1'b0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        newdat_q[g] <= 1'b0;
        msglst_q[g] <= 1'b0;
        intpnd_q[g] <= 1'b0;
      end else if (store && win_idx == IDX_W'(g)) begin
        newdat_q[g] <= 1'b1;
        msglst_q[g] <= msglst_q[g] | newdat_q[g];
        intpnd_q[g] <= intpnd_q[g] | cfg_q[g].rxie;
      end
    end
  end

  prio_lowest #(.N(NUM_OBJ)) u_prio (
    .req  (match_vec),
    .found(any_match),
    .idx  (win_idx)
  );

  obj_store #(.N(NUM_OBJ), .W(MEM_W)) u_store (
    .clk  (clk),
    .we   (store),
    .waddr(win_idx),
    .wdata({frm_dlc, frm_data}),
    .raddr(rd_idx),
    .rdata(rd_word)
  );

  assign rd_data = rd_word[DATA_W-1:0];
  assign rd_dlc  = rd_word[MEM_W-1:DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      nomatch <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit     <= store;
      nomatch <= frm_valid && !any_match;
      if (store) hit_idx <= win_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_newdat <= 1'b0;
      rd_msglst <= 1'b0;
      rd_intpnd <= 1'b0;
    end else begin
      rd_newdat <= newdat_q[rd_idx];
      rd_msglst <= msglst_q[rd_idx];
      rd_intpnd <= intpnd_q[rd_idx];
    end
  end

  assert_hit_nomatch_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(hit && nomatch));

  assert_strobe_origin_R12: assert property (@(posedge clk) disable iff (rst)
    (hit || nomatch) |-> $past(frm_valid));

  assert_newdat_on_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && !($past(cfg_we) && $past(cfg_idx) == hit_idx)) |-> newdat_q[hit_idx]);

  assert_nomatch_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (nomatch && !$past(cfg_we)) |-> ($stable(newdat_q) && $stable(msglst_q) && $stable(intpnd_q)));
endmodule

// File: tb/rx_obj_filter_test.sv
module rx_obj_filter_test;
  localparam int N = 32;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic        cfg_we = 0;
  logic [4:0]  cfg_idx = 0;
  logic [28:0] cfg_id = 0, cfg_mask = 0;
  logic        cfg_xtd = 0, cfg_dir = 0, cfg_valid = 0, cfg_umask = 0;
  logic        cfg_mxtd = 0, cfg_mdir = 0, cfg_rxie = 0;
  logic        frm_valid = 0, frm_xtd = 0, frm_dir = 0;
  logic [28:0] frm_id = 0;
  logic [3:0]  frm_dlc = 0;
  logic [63:0] frm_data = 0;
  logic        hit, nomatch;
  logic [4:0]  hit_idx;
  logic [4:0]  rd_idx = 0;
  logic [63:0] rd_data;
  logic [3:0]  rd_dlc;
  logic        rd_newdat, rd_msglst, rd_intpnd;

  rx_obj_filter uut (.*);

  // reference model
  logic [28:0] m_id [N], m_mask [N];
  bit          m_xtd [N], m_dir [N], m_val [N], m_um [N], m_mx [N], m_md [N], m_ie [N];
  bit          m_nd [N], m_ml [N], m_ip [N];
  logic [3:0]  m_dlc [N];
  logic [63:0] m_data [N];

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_match(int i, logic [28:0] fid, bit fx, bit fd);
    logic [28:0] msk;
    bit cx, cd;
    if (!m_val[i] || m_dir[i]) return 0;          // R2
    msk = m_um[i] ? m_mask[i] : '1;                // R3/R4
    if (!fx) msk = msk & {11'h7FF, 18'h0};         // R5
    cx = m_um[i] ? m_mx[i] : 1'b1;                 // R6
    cd = m_um[i] ? m_md[i] : 1'b1;
    if (((fid ^ m_id[i]) & msk) != 0) return 0;
    if (cx && fx != m_xtd[i]) return 0;
    if (cd && fd != m_dir[i]) return 0;
    return 1;
  endfunction

  task automatic cfg_obj(int i, logic [28:0] id, logic [28:0] mask, bit val, bit dir,
                         bit xtd, bit um, bit mx, bit md, bit ie);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(i); cfg_id = id; cfg_mask = mask; cfg_valid = val;
    cfg_dir = dir; cfg_xtd = xtd; cfg_umask = um; cfg_mxtd = mx; cfg_mdir = md; cfg_rxie = ie;
    @(negedge clk);
    cfg_we = 0;
    m_id[i] = id; m_mask[i] = mask; m_val[i] = val; m_dir[i] = dir; m_xtd[i] = xtd;
    m_um[i] = um; m_mx[i] = mx; m_md[i] = md; m_ie[i] = ie;
    m_nd[i] = 0; m_ml[i] = 0; m_ip[i] = 0;       // R13
  endtask

  task automatic read_check(int i, string req, bit with_data);
    int nb;
    rd_idx = 5'(i);
    @(negedge clk);                                // R12: one cycle read latency
    chk({rd_newdat, rd_msglst, rd_intpnd} == {m_nd[i], m_ml[i], m_ip[i]},
        {req, " flags nd/ml/ip (R9 R10)"},
        {61'd0, rd_newdat, rd_msglst, rd_intpnd}, {61'd0, m_nd[i], m_ml[i], m_ip[i]});
    if (with_data) begin
      chk(rd_dlc == m_dlc[i], {req, " stored DLC R8"}, 64'(rd_dlc), 64'(m_dlc[i]));
      nb = (m_dlc[i] > 8) ? 8 : int'(m_dlc[i]);
      for (int k = 0; k < nb; k++)
        chk(rd_data[8*k +: 8] == m_data[i][8*k +: 8], {req, " data byte R8"},
            64'(rd_data[8*k +: 8]), 64'(m_data[i][8*k +: 8]));
    end
  endtask

  task automatic send(logic [28:0] fid, bit fx, bit fd, logic [3:0] dlc, logic [63:0] data, string req);
    int exp_i = -1;
    for (int i = N - 1; i >= 0; i--) if (ref_match(i, fid, fx, fd)) exp_i = i;   // R7
    @(negedge clk);
    frm_valid = 1; frm_id = fid; frm_xtd = fx; frm_dir = fd; frm_dlc = dlc; frm_data = data;
    @(negedge clk);
    frm_valid = 0;
    chk(hit == (exp_i >= 0) && nomatch == (exp_i < 0), {req, " hit/nomatch R12 R11"},
        {62'd0, hit, nomatch}, {62'd0, exp_i >= 0, exp_i < 0});
    if (exp_i >= 0) begin
      chk(hit_idx == 5'(exp_i), {req, " winner index R7"}, 64'(hit_idx), 64'(exp_i));
      m_ml[exp_i] = m_ml[exp_i] | m_nd[exp_i];
      m_nd[exp_i] = 1;
      m_ip[exp_i] = m_ip[exp_i] | m_ie[exp_i];
      m_dlc[exp_i] = dlc; m_data[exp_i] = data;
      read_check(exp_i, req, 1);
    end else begin
      read_check(int'($urandom % N), {req, " untouched R11"}, 0);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [28:0] a, s, fid, msk;
    int j;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) begin
      m_id[i] = 0; m_mask[i] = 0; m_val[i] = 0; m_dir[i] = 0; m_xtd[i] = 0; m_um[i] = 0;
      m_mx[i] = 0; m_md[i] = 0; m_ie[i] = 0; m_nd[i] = 0; m_ml[i] = 0; m_ip[i] = 0;
      m_dlc[i] = 0; m_data[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!hit && !nomatch, "reset outputs R1", {62'd0, hit, nomatch}, 0);
    read_check(0, "reset R1", 0);
    send(29'h0ABC_DEF, 1, 0, 4'd8, 64'h1122_3344_5566_7788, "empty bank R1");

    // qualification and exact matching
    a = 29'h1234_5678;
    cfg_obj(3, a, '0, 0, 0, 1, 0, 0, 0, 1);   // invalid
    cfg_obj(4, a, '0, 1, 1, 1, 0, 0, 0, 1);   // transmit object
    cfg_obj(9, a, '0, 1, 0, 1, 0, 0, 0, 1);
    send(a, 1, 0, 4'd8, 64'h0807_0605_0403_0201, "exact R2 R3");
    send(a, 1, 0, 4'd3, 64'hDEAD_BEEF_00C0_FFEE, "overwrite R9 R10");
    send(a ^ 29'h1, 1, 0, 4'd8, 64'h1, "id mismatch R3");
    send(a, 1, 1, 4'd8, 64'h2, "dir mismatch R3");
    send(a, 0, 0, 4'd8, 64'h3, "xtd mismatch R3");
    cfg_obj(9, a, '0, 1, 0, 1, 0, 0, 0, 0);
    read_check(9, "config clears R13", 0);

    // standard identifiers left-aligned
    s = {11'h5A3, 18'h3_1234};
    cfg_obj(12, s, '0, 1, 0, 0, 0, 0, 0, 0);
    send({11'h5A3, 18'h0_0F0F}, 0, 0, 4'd2, 64'hAAAA, "standard low bits ignored R5");
    send({11'h5A2, 18'h3_1234}, 0, 0, 4'd2, 64'hBBBB, "standard id differs R5");

    // masking
    cfg_obj(20, 29'h1000_0000, 29'h1000_0000, 1, 0, 1, 1, 0, 1, 1);
    send(29'h1FFF_FFFF, 0, 0, 4'd5, 64'h55, "mask bit28 only R4 R6");
    send(29'h0FFF_FFFF, 1, 0, 4'd5, 64'h66, "mask bit28 differs R4");
    send(29'h1000_0000, 1, 1, 4'd5, 64'h77, "mdir compares dir R6");
    cfg_obj(25, 29'h0, 29'h0, 1, 0, 0, 1, 0, 0, 0);
    send(29'h0000_0001, 1, 1, 4'd7, 64'h99, "zero mask accepts all R4 R6");
    cfg_obj(0, 29'h7, 29'h0, 1, 0, 1, 1, 0, 0, 1);
    send(29'h0000_0001, 1, 1, 4'd7, 64'hAB, "lowest index wins R7");
    cfg_obj(0, 29'h0, 29'h0, 0, 0, 0, 0, 0, 0, 0);
    cfg_obj(25, 29'h0, 29'h0, 0, 0, 0, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < N; i++) begin
      msk = 29'($urandom & $urandom & $urandom);
      cfg_obj(i, 29'($urandom), msk, ($urandom % 8) != 0, ($urandom % 10) == 0,
              bit'($urandom), bit'($urandom), bit'($urandom), bit'($urandom), bit'($urandom));
    end
    for (int t = 0; t < 400; t++) begin
      j = int'($urandom % N);
      fid = m_id[j];
      if ($urandom % 3 == 0) fid = fid ^ (29'd1 << ($urandom % 29));
      send(fid, ($urandom % 6 == 0) ? !m_xtd[j] : m_xtd[j], ($urandom % 8) == 0,
           4'($urandom), {$urandom, $urandom}, "random R3 R4 R5 R6 R7 R8");
      if (t % 15 == 0)
        cfg_obj(j, m_id[j], m_mask[j], m_val[j], m_dir[j], m_xtd[j], m_um[j], m_mx[j], m_md[j], m_ie[j]);
    end
    finish_run();
  end
endmodule